// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter (Bus Master)

This block drives a two-slot audio serial link as bus master. It produces four outputs: a master clock, a bit clock, a word select and serial data. All four come from one fast system clock through two integer dividers. Each frame carries a left slot and then a right slot. Each slot is sent most-significant bit first and lasts one bit clock per data bit.

Three framings share one engine:
- a format whose data lags word select by one bit;
- a format whose data is aligned with word select;
- a short-pulse format that marks each frame with a one-bit sync pulse.

Samples arrive as stereo pairs over a valid/ready handshake. The block takes a pair only at a frame boundary. If no pair is ready at that point, the block sends silence and raises a sticky flag.

The configuration is captured while the port is disabled. It covers slot width, framing, mono/stereo, both divider ratios and the output polarities. The block ignores configuration inputs while it is running. After enable, one lead-in bit period comes first, and then the MSB of a left slot.

Top module: `aud_serial_tx`

## Requirements
- R1: The width code selects the slot width W: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. A frame is 2W bit clocks: the left slot, then the right slot. Each slot sends bits [W-1:0] of its sample, MSB first. Higher sample bits are ignored.
- R2: With format code 0 (lagging), word select is low for the left half and high for the right half. It changes one bit clock before the MSB of each slot.
- R3: With format code 1 (aligned), word select is high exactly for the W bit clocks of the right slot. It changes in the same bit clock as each slot's MSB.
- R4: With format code 2 or 3 (pulse), word select is high for exactly one bit clock, the last of each frame. The left MSB follows in the next bit clock.
- R5: While enabled, the master clock period is 2*(mclk_div+1) system clocks. The bit clock period is 2*(bclk_div+1) master clock periods. While disabled, the master clock is low and the internal bit clock is high.
- R6: Separate controls invert the bit clock output and the word select output. The inversion also applies while the port is idle.
- R7: When mono is set, each frame takes only the left sample, and that sample is sent in both slots. The right sample input is ignored.
- R8: in_ready_o is high for one system clock at each frame start. A pair offered with in_valid_i in that cycle is the pair sent in that frame.
- R9: If in_valid_i is low when in_ready_o is high, the frame sends zeros and underrun_o is set. underrun_o stays set while enabled and clears while disabled.
- R10: Data and word select change only when the internal bit clock falls, so they are stable at its rising edge.
- R11: The configuration inputs are captured only while enable_i is low. After enable, the block sends one lead-in bit period with data 0, placed as the last bit of a frame. The left MSB follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Port run enable; configuration is captured while low |
| cfg_fmt_i | input | 2 | Framing code: 0 lagging, 1 aligned, 2/3 pulse |
| cfg_width_i | input | 2 | Slot width code (8/16/24/32) |
| cfg_mono_i | input | 1 | Mono: left sample sent in both slots |
| cfg_inv_bclk_i | input | 1 | Invert bit clock output |
| cfg_inv_ws_i | input | 1 | Invert word select output |
| cfg_mdiv_i | input | DIV_W | Master clock half-period minus one, in system clocks |
| cfg_bdiv_i | input | DIV_W | Bit clock half-period minus one, in master clocks |
| in_valid_i | input | 1 | Stereo pair available |
| in_ready_o | output | 1 | Pair accepted this cycle (frame start) |
| in_left_i | input | SMP_W | Left sample, MSB at bit W-1 |
| in_right_i | input | SMP_W | Right sample, MSB at bit W-1 |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select / frame sync |
| dout_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky missing-sample flag |

## Verification
Two events share one cycle: the frame-start pair acceptance, and the underrun decision for the frame that begins there. The bench holds in_valid_i low through the first frame boundary, then raises it mid-frame. It checks that the first frame is silent and that the flag rises. It checks that the second frame carries the new pair while the flag stays set. Disabling the port must then clear the flag.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic [1:0] {
      FMT_LAG      = 2'd0,
      FMT_ALIGN    = 2'd1,
      FMT_PULSE    = 2'd2,
      FMT_PULSE_B  = 2'd3
   } fmt_e;

   typedef struct packed {
      fmt_e       fmt;
      logic [1:0] wsel;
      logic       mono;
      logic       inv_bclk;
      logic       inv_ws;
   } cfg_t;

   // slot width in bit clocks from the width code
   function automatic logic [5:0] slot_bits(input logic [1:0] wsel);
      return {1'b0, wsel, 3'b000} + 6'd8;
   endfunction

endpackage

// File: rtl/aud_clk_gen.sv
module aud_clk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] mdiv,
   input  logic [DIV_W-1:0] bdiv,
   output logic             mclk,
   output logic             bclk,
   output logic             fall_stb
);

   logic [DIV_W-1:0] mcnt_q, bcnt_q;
   logic             mclk_q, bclk_q;
   logic             m_wrap, m_rise, b_wrap;

   assign m_wrap   = run && (mcnt_q == mdiv);
   assign m_rise   = m_wrap && !mclk_q;
   assign b_wrap   = m_rise && (bcnt_q == bdiv);
   assign fall_stb = b_wrap && bclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt_q <= '0;
         bcnt_q <= '0;
         mclk_q <= 1'b0;
         bclk_q <= 1'b1;
      end else if (!run) begin
         mcnt_q <= '0;
         bcnt_q <= '0;
         mclk_q <= 1'b0;
         bclk_q <= 1'b1;
      end else begin
         mcnt_q <= m_wrap ? '0 : mcnt_q + 1'b1;
         if (m_wrap) mclk_q <= ~mclk_q;
         if (m_rise) bcnt_q <= b_wrap ? '0 : bcnt_q + 1'b1;
         if (b_wrap) bclk_q <= ~bclk_q;
      end
   end

   assign mclk = mclk_q;
   assign bclk = bclk_q;

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
   import aud_tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       step,
   input  fmt_e       fmt,
   input  logic [5:0] wbits,
   output logic [5:0] pos_n,
   output logic       frame_start,
   output logic       ws
);

   logic [5:0] pos_q, last;
   logic [6:0] span;
   logic       ws_n, ws_q;

   assign span        = {wbits, 1'b0};
   assign last        = 6'(span - 7'd1);
   assign pos_n       = (pos_q == last) ? 6'd0 : pos_q + 6'd1;
   assign frame_start = step && (pos_n == 6'd0);

   always_comb begin
      unique case (fmt)
         FMT_LAG:   ws_n = (pos_n >= wbits - 6'd1) && (pos_n != last);
         FMT_ALIGN: ws_n = (pos_n >= wbits);
         default:   ws_n = (pos_n == last);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         ws_q  <= 1'b0;
      end else if (!run) begin
         pos_q <= last - 6'd1;
         ws_q  <= 1'b0;
      end else if (step) begin
         pos_q <= pos_n;
         ws_q  <= ws_n;
      end
   end

   assign ws = ws_q;

endmodule

// File: rtl/aud_slot_data.sv
module aud_slot_data #(
   parameter int SMP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic             frame_start,
   input  logic             mono,
   input  logic             in_valid,
   input  logic [SMP_W-1:0] in_left,
   input  logic [SMP_W-1:0] in_right,
   input  logic [5:0]       pos_n,
   input  logic [5:0]       wbits,
   output logic             dout,
   output logic             underrun
);

   logic [SMP_W-1:0] left_q, right_q, cur_l, cur_r, new_r;
   logic             slot, bit_n, dout_q, urun_q;
   logic [5:0]       off;
   logic [4:0]       idx;

   assign new_r = mono ? in_left : in_right;
   assign cur_l = frame_start ? (in_valid ? in_left : '0) : left_q;
   assign cur_r = frame_start ? (in_valid ? new_r : '0) : right_q;
   assign slot  = (pos_n >= wbits);
   assign off   = slot ? pos_n - wbits : pos_n;
   assign idx   = 5'(wbits - 6'd1 - off);
   assign bit_n = slot ? cur_r[idx] : cur_l[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         right_q <= '0;
         dout_q  <= 1'b0;
         urun_q  <= 1'b0;
      end else if (!run) begin
         left_q  <= '0;
         right_q <= '0;
         dout_q  <= 1'b0;
         urun_q  <= 1'b0;
      end else begin
         if (frame_start) begin
            left_q  <= cur_l;
            right_q <= cur_r;
            if (!in_valid) urun_q <= 1'b1;
         end
         if (step) dout_q <= bit_n;
      end
   end

   assign dout     = dout_q;
   assign underrun = urun_q;

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
   import aud_tx_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int SMP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic [1:0]       cfg_fmt_i,
   input  logic [1:0]       cfg_width_i,
   input  logic             cfg_mono_i,
   input  logic             cfg_inv_bclk_i,
   input  logic             cfg_inv_ws_i,
   input  logic [DIV_W-1:0] cfg_mdiv_i,
   input  logic [DIV_W-1:0] cfg_bdiv_i,
   input  logic             in_valid_i,
   output logic             in_ready_o,
   input  logic [SMP_W-1:0] in_left_i,
   input  logic [SMP_W-1:0] in_right_i,
   output logic             mclk_o,
   output logic             bclk_o,
   output logic             ws_o,
   output logic             dout_o,
   output logic             underrun_o
);

   localparam int MAX_SLOT = 32;

   generate
      if (SMP_W < MAX_SLOT) begin : g_bad_smp
         $error("SMP_W must hold the widest slot");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   cfg_t             cfg_q;
   logic [DIV_W-1:0] mdiv_q, bdiv_q;
   logic             run, bclk_int, ws_int, fall_stb, frame_start;
   logic [5:0]       wbits, pos_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         cfg_q  <= '0;
         mdiv_q <= '0;
         bdiv_q <= '0;
      end else begin
         run <= enable_i;
         if (!enable_i) begin
            cfg_q  <= '{fmt: fmt_e'(cfg_fmt_i), wsel: cfg_width_i, mono: cfg_mono_i,
                        inv_bclk: cfg_inv_bclk_i, inv_ws: cfg_inv_ws_i};
            mdiv_q <= cfg_mdiv_i;
            bdiv_q <= cfg_bdiv_i;
         end
      end
   end

   assign wbits = slot_bits(cfg_q.wsel);

   aud_clk_gen #(.DIV_W(DIV_W)) clk_gen_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .mdiv     (mdiv_q),
      .bdiv     (bdiv_q),
      .mclk     (mclk_o),
      .bclk     (bclk_int),
      .fall_stb (fall_stb)
   );

   aud_frame_seq seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .step        (fall_stb),
      .fmt         (cfg_q.fmt),
      .wbits       (wbits),
      .pos_n       (pos_n),
      .frame_start (frame_start),
      .ws          (ws_int)
   );

   aud_slot_data #(.SMP_W(SMP_W)) data_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .step        (fall_stb),
      .frame_start (frame_start),
      .mono        (cfg_q.mono),
      .in_valid    (in_valid_i),
      .in_left     (in_left_i),
      .in_right    (in_right_i),
      .pos_n       (pos_n),
      .wbits       (wbits),
      .dout        (dout_o),
      .underrun    (underrun_o)
   );

   assign in_ready_o = frame_start;
   assign bclk_o     = bclk_int ^ cfg_q.inv_bclk;
   assign ws_o       = ws_int ^ cfg_q.inv_ws;

endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic       enable,
   input logic       bclk_int,
   input logic       dout,
   input logic       in_ready,
   input logic       in_valid,
   input logic       underrun,
   input logic       mclk,
   input logic [6:0] cfg_word
);

   AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(dout)) |-> $fell(bclk_int)); // R10

   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready); // R8

   AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid && enable) |=> underrun); // R9

   AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && enable) |=> underrun); // R9

   AST_MCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> !mclk); // R5

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(cfg_word)); // R11

endmodule

bind aud_serial_tx aud_serial_tx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .enable   (enable_i),
   .bclk_int (bclk_int),
   .dout     (dout_o),
   .in_ready (in_ready_o),
   .in_valid (in_valid_i),
   .underrun (underrun_o),
   .mclk     (mclk_o),
   .cfg_word (cfg_q)
);

// File: tb/aud_serial_tx_tb_top.sv
module aud_serial_tx_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 150000;

   typedef struct packed {
      logic [1:0]  fmt;
      logic [1:0]  wsel;
      logic        mono;
      logic        invb;
      logic        invw;
      logic [3:0]  mdiv;
      logic [3:0]  bdiv;
      logic [31:0] l;
      logic [31:0] r;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h0000A5C3, 32'h00003C0F},
      '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h0000A5C3, 32'h00003C0F},
      '{2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'h0000A5C3, 32'h00003C0F},
      '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 4'd1, 4'd1, 32'h00C0FFEE, 32'h00123456},
      '{2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 32'hDEADBEEF, 32'h80000001},
      '{2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 4'd0, 4'd1, 32'hFFFFFF96, 32'h1234565A},
      '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 32'h00000081, 32'h0000007E},
      '{2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 32'h12345678, 32'hFFFFFFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable_i = 1'b0;
   logic [1:0]  cfg_fmt_i = '0;
   logic [1:0]  cfg_width_i = '0;
   logic        cfg_mono_i = 1'b0;
   logic        cfg_inv_bclk_i = 1'b0;
   logic        cfg_inv_ws_i = 1'b0;
   logic [7:0]  cfg_mdiv_i = '0;
   logic [7:0]  cfg_bdiv_i = '0;
   logic        in_valid_i = 1'b0;
   logic [31:0] in_left_i = '0;
   logic [31:0] in_right_i = '0;
   logic        in_ready_o, mclk_o, bclk_o, ws_o, dout_o, underrun_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int obs_err, obs_hs, obs_k, obs_act, obs_exp;
   int r10_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   aud_serial_tx #(.DIV_W(8), .SMP_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
      .cfg_fmt_i(cfg_fmt_i), .cfg_width_i(cfg_width_i), .cfg_mono_i(cfg_mono_i),
      .cfg_inv_bclk_i(cfg_inv_bclk_i), .cfg_inv_ws_i(cfg_inv_ws_i),
      .cfg_mdiv_i(cfg_mdiv_i), .cfg_bdiv_i(cfg_bdiv_i),
      .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
      .in_left_i(in_left_i), .in_right_i(in_right_i),
      .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .dout_o(dout_o),
      .underrun_o(underrun_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   // expected word select per framing code, position p in frame of 2w bits
   function automatic bit exp_ws(input int fmt, input int w, input int p);
      if (fmt == 0)      return (p >= w - 1) && (p != 2*w - 1);
      else if (fmt == 1) return p >= w;
      else               return p == 2*w - 1;
   endfunction

   function automatic bit exp_bit(input int w, input bit mono, input int p,
                                  input logic [31:0] l, input logic [31:0] r);
      logic [31:0] src;
      int b;
      if (p >= w) begin
         src = mono ? l : r;
         b   = 2*w - 1 - p;
      end else begin
         src = l;
         b   = w - 1 - p;
      end
      return src[b];
   endfunction

   // watches n bit-clock rising edges; k0 = index of first edge (0 = lead-in)
   task automatic observe(input int n, input int k0, input int fmt, input int w,
                          input bit mono, input bit invb, input bit invw,
                          input logic [31:0] l, input logic [31:0] r);
      bit prev, cur, ew, ed, last_d;
      int k, p;
      prev   = bclk_o ^ invb;
      last_d = dout_o;
      k = k0;
      obs_err = 0;
      obs_hs  = 0;
      while (k < k0 + n) begin
         @(negedge clk);
         if (in_ready_o && in_valid_i) obs_hs++;
         cur = bclk_o ^ invb;
         if (prev && cur && (dout_o != last_d)) r10_err++;
         if (!prev && cur) begin
            p  = (k == 0) ? 2*w - 1 : (k - 1) % (2*w);
            ew = exp_ws(fmt, w, p);
            ed = (k == 0) ? 1'b0 : exp_bit(w, mono, p, l, r);
            if ({ws_o ^ invw, dout_o} != {ew, ed}) begin
               if (obs_err == 0) begin
                  obs_k   = k;
                  obs_act = {ws_o ^ invw, dout_o};
                  obs_exp = {ew, ed};
               end
               obs_err++;
            end
            k++;
         end
         prev   = cur;
         last_d = dout_o;
      end
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG_CYC, 0);
      summary();
      $finish;
   end

   initial begin
      int t0, t1, w;
      string tag;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // reset / idle state
      check({mclk_o, bclk_o, ws_o, dout_o, in_ready_o, underrun_o} == 6'b010000,
            "R5 idle after reset", {mclk_o, bclk_o, ws_o, dout_o, in_ready_o, underrun_o}, 6'b010000);

      // idle polarity inversion
      cfg_inv_bclk_i = 1'b1;
      cfg_inv_ws_i   = 1'b1;
      repeat (2) @(negedge clk);
      check({bclk_o, ws_o} == 2'b01, "R6 idle inversion", {bclk_o, ws_o}, 2'b01);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         cfg_fmt_i      = VECS[v].fmt;
         cfg_width_i    = VECS[v].wsel;
         cfg_mono_i     = VECS[v].mono;
         cfg_inv_bclk_i = VECS[v].invb;
         cfg_inv_ws_i   = VECS[v].invw;
         cfg_mdiv_i     = {4'd0, VECS[v].mdiv};
         cfg_bdiv_i     = {4'd0, VECS[v].bdiv};
         in_left_i      = VECS[v].l;
         in_right_i     = VECS[v].r;
         in_valid_i     = 1'b1;
         w = 8 * (int'(VECS[v].wsel) + 1);
         repeat (4) @(negedge clk);
         enable_i = 1'b1;
         @(negedge clk);
         // R11: scrambled configuration while running must have no effect
         cfg_fmt_i      = ~VECS[v].fmt;
         cfg_width_i    = ~VECS[v].wsel;
         cfg_mono_i     = ~VECS[v].mono;
         cfg_inv_bclk_i = ~VECS[v].invb;
         cfg_inv_ws_i   = ~VECS[v].invw;
         cfg_mdiv_i     = 8'd7;
         cfg_bdiv_i     = 8'd5;
         observe(1 + 6*w, 0, VECS[v].fmt, w, VECS[v].mono, VECS[v].invb, VECS[v].invw,
                 VECS[v].l, VECS[v].r);
         enable_i = 1'b0;
         tag = (VECS[v].fmt == 0) ? "R2" : (VECS[v].fmt == 1) ? "R3" : "R4";
         tag = $sformatf("%s R1 R11%s%s vec %0d bit %0d", tag,
                         VECS[v].mono ? " R7" : "",
                         (VECS[v].invb || VECS[v].invw) ? " R6" : "", v, obs_k);
         check(obs_err == 0, tag, obs_act, obs_exp);
         check(obs_hs == 3, $sformatf("R8 handshakes vec %0d", v), obs_hs, 3);
         check(underrun_o == 1'b0, $sformatf("R9 no underrun vec %0d", v), underrun_o, 0);
         @(negedge clk);
      end
      check(r10_err == 0, "R10 data stable while bit clock high", r10_err, 0);

      // clock ratios: mdiv 2 -> 6 clocks, bdiv 1 -> 4 master periods
      cfg_fmt_i = 2'd0; cfg_width_i = 2'd0; cfg_mono_i = 1'b0;
      cfg_inv_bclk_i = 1'b0; cfg_inv_ws_i = 1'b0;
      cfg_mdiv_i = 8'd2; cfg_bdiv_i = 8'd1;
      repeat (3) @(negedge clk);
      enable_i = 1'b1;
      repeat (3) @(posedge mclk_o);
      @(negedge clk); t0 = cyc;
      @(posedge mclk_o);
      @(negedge clk); t1 = cyc;
      check(t1 - t0 == 6, "R5 master clock period", t1 - t0, 6);
      @(posedge bclk_o);
      @(negedge clk); t0 = cyc;
      @(posedge bclk_o);
      @(negedge clk); t1 = cyc;
      check(t1 - t0 == 24, "R5 bit clock period", t1 - t0, 24);
      enable_i = 1'b0;
      repeat (3) @(negedge clk);

      // underrun at the first boundary, then data offered mid-frame
      cfg_fmt_i = 2'd1; cfg_width_i = 2'd0;
      cfg_mdiv_i = 8'd0; cfg_bdiv_i = 8'd0;
      in_valid_i = 1'b0;
      in_left_i  = 32'h000000A5;
      in_right_i = 32'h0000003C;
      repeat (3) @(negedge clk);
      enable_i = 1'b1;
      observe(17, 0, 1, 8, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
      check(obs_err == 0, "R9 zeros sent on underrun", obs_act, obs_exp);
      check(underrun_o == 1'b1, "R9 underrun raised", underrun_o, 1);
      in_valid_i = 1'b1;
      observe(16, 17, 1, 8, 1'b0, 1'b0, 1'b0, 32'hA5, 32'h3C);
      check(obs_err == 0 && obs_hs == 1, "R8 pair sent after late valid", obs_act, obs_exp);
      check(underrun_o == 1'b1, "R9 underrun sticky", underrun_o, 1);
      enable_i = 1'b0;
      repeat (2) @(negedge clk);
      check(underrun_o == 1'b0, "R9 underrun cleared when disabled", underrun_o, 0);

      summary();
      $finish;
   end

endmodule